// File: doc/BRIEF.md
# Transmit Descriptor Ring Poller

This block keeps a small ring of transmit buffer descriptors in registers and decides which buffer a downstream frame engine should send next. Software fills descriptors through a write port: a ready flag, a wrap flag, an end-of-frame flag, a checksum-request flag and a byte count. A status field is cleared on every write. While transmission is enabled and no frame is in flight, the poller examines the descriptor at the current ring position. It does this either when a fixed interval timer expires or as soon as software raises an on-demand request.

When the examined descriptor is ready, the poller presents it to the frame engine. From then on it follows the descriptors of that frame without polling again. Each completed buffer has its ready flag cleared. Only the buffer that ends the frame also receives the engine's status word. A collision report sends the poller back to the first descriptor of the frame in flight, so the whole frame is offered again. A combinational read port lets software inspect any descriptor's ready flag and status.

Top module: `txr_ring_poller`

## Requirements
- R1: After reset every descriptor reads not ready with status 0, `buf_valid` is 0, `demand_pending` is 0 and the ring position is entry 0.
- R2: While `tx_enable` is 1 and no frame is in flight, the current descriptor is examined once every POLL_CYCLES (default 128) clock cycles. With enable first seen at a clock edge, a ready descriptor raises `buf_valid` after the 128th edge and not before.
- R3: A pulse on `demand_set` raises `demand_pending` at the next edge. If the poller is enabled and idle, the following edge examines the descriptor, which clears `demand_pending` and restarts the interval.
- R4: Examining a descriptor whose ready flag is 0 hands nothing to the engine and leaves the ring position unchanged.
- R5: When `eng_done` arrives for a descriptor with its end-of-frame flag set, that descriptor's ready flag is cleared, its status takes `eng_status`, and `buf_valid` falls at the same edge.
- R6: When `eng_done` arrives for a descriptor without the end-of-frame flag, only its ready flag is cleared and its status is unchanged. The next descriptor is presented at once, with `buf_valid` held at 1 and its ready flag not examined.
- R7: `eng_collision` during a frame returns `buf_idx` to the frame's first descriptor at the next edge, with `buf_valid` held at 1. Collision takes priority over `eng_done`.
- R8: After a completed descriptor whose wrap flag is set, or after entry NUM_DESC-1, the ring position becomes entry 0.
- R9: `buf_crc_append` equals the checksum-request flag of the presented descriptor only when that descriptor ends the frame, and is 0 otherwise.
- R10: While `tx_enable` is 0, no descriptor is examined, and a pending demand stays pending until the poller is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Transmit enable; polling runs only while 1 |
| dsc_wr_en | input | 1 | Descriptor write strobe |
| dsc_wr_idx | input | IDX_W | Descriptor entry to write |
| dsc_wr_ready | input | 1 | Ready flag to write |
| dsc_wr_wrap | input | 1 | Wrap flag to write |
| dsc_wr_last | input | 1 | End-of-frame flag to write |
| dsc_wr_crc | input | 1 | Checksum-request flag to write |
| dsc_wr_len | input | LEN_W | Buffer byte count to write |
| demand_set | input | 1 | On-demand poll request pulse |
| dsc_rd_idx | input | IDX_W | Descriptor entry to read |
| dsc_rd_ready | output | 1 | Ready flag of the entry read |
| dsc_rd_status | output | ST_W | Status field of the entry read |
| demand_pending | output | 1 | On-demand request waiting to be served |
| buf_valid | output | 1 | A buffer is presented to the frame engine |
| buf_idx | output | IDX_W | Ring position presented |
| buf_len | output | LEN_W | Byte count of the presented buffer |
| buf_last | output | 1 | Presented buffer ends the frame |
| buf_crc_append | output | 1 | Engine should append the checksum |
| eng_done | input | 1 | Engine finished the presented buffer |
| eng_collision | input | 1 | Engine saw a collision on the current frame |
| eng_status | input | ST_W | Frame status to store on end-of-frame completion |

## Verification
The assertions assume that `eng_done` and `eng_collision` are raised only while `buf_valid` is 1, for a single cycle each. They also assume that software never writes the descriptor the engine completes in that same cycle, and that every descriptor of a frame is written before the frame's first one is marked ready. The bench keeps to these assumptions. Its engine tasks pulse completion or collision only after observing `buf_valid`. Descriptor writes take place only while the entry concerned is idle, and multi-buffer frames are written starting at the tail so that the head goes ready last.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int LEN_W = 11;
  localparam int ST_W  = 4;

  typedef struct packed {
    logic            ready;
    logic            wrap;
    logic            last;
    logic            crc;
    logic [LEN_W-1:0] len;
    logic [ST_W-1:0]  status;
  } txr_desc_t;
endpackage

// File: rtl/txr_poll_timer.sv
module txr_poll_timer #(
  parameter int POLL_CYCLES = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
  localparam logic [CW-1:0] TOP = CW'(POLL_CYCLES - 1);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count_q <= '0;
    else if (!run || restart)  count_q <= '0;
    else                       count_q <= count_q + 1'b1;
  end

  assign tick = (count_q == TOP);

  // R2: the interval counter never runs past its last value
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= TOP);
endmodule

// File: rtl/txr_desc_file.sv
module txr_desc_file
  import txr_pkg::*;
#(
  parameter int NUM_DESC = 8,
  localparam int IDX_W = $clog2(NUM_DESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  txr_desc_t        wr_desc,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_status_en,
  input  logic [ST_W-1:0]  upd_status,
  input  logic [IDX_W-1:0] cur_idx,
  output txr_desc_t        cur_desc,
  input  logic [IDX_W-1:0] rd_idx,
  output txr_desc_t        rd_desc
);
  txr_desc_t ents [NUM_DESC];

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ents[i] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        ents[i] <= wr_desc;
      end else if (upd_en && upd_idx == IDX_W'(i)) begin
        ents[i].ready <= 1'b0;
        if (upd_status_en) ents[i].status <= upd_status;
      end
    end
  end

  assign cur_desc = ents[cur_idx];
  assign rd_desc  = ents[rd_idx];

  // R6: a completion without status leaves the stored status untouched
  a_r6_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_status_en && !(wr_en && wr_idx == upd_idx) && cur_idx == upd_idx)
      |=> (ents[$past(upd_idx)].status == $past(cur_desc.status)) && !ents[$past(upd_idx)].ready);
endmodule

// File: rtl/txr_ring_ctrl.sv
module txr_ring_ctrl #(
  parameter int NUM_DESC = 8,
  localparam int IDX_W = $clog2(NUM_DESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             demand_set,
  input  logic             tick,
  input  logic             cur_ready,
  input  logic             cur_last,
  input  logic             cur_wrap,
  input  logic             done,
  input  logic             collision,
  output logic             busy,
  output logic [IDX_W-1:0] cur_idx,
  output logic             demand_q,
  output logic             poll_fire,
  output logic             timer_run,
  output logic             upd_en,
  output logic             upd_status_en
);
  logic [IDX_W-1:0] start_q;
  logic [IDX_W-1:0] nxt_idx;
  logic             take_frame;
  logic             rewind;
  logic             finish_buf;

  function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] idx,
                                                 input logic wrap);
    if (wrap || idx == IDX_W'(NUM_DESC - 1)) return '0;
    return idx + 1'b1;
  endfunction

  assign timer_run     = enable && !busy;
  assign poll_fire     = timer_run && (tick || demand_q);
  assign take_frame    = poll_fire && cur_ready;
  assign rewind        = busy && collision;
  assign finish_buf    = busy && done && !collision;
  assign nxt_idx       = ring_next(cur_idx, cur_wrap);
  assign upd_en        = finish_buf;
  assign upd_status_en = finish_buf && cur_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_idx  <= '0;
      start_q  <= '0;
      demand_q <= 1'b0;
    end else begin
      demand_q <= demand_set || (demand_q && !poll_fire);
      if (take_frame) begin
        busy    <= 1'b1;
        start_q <= cur_idx;
      end else if (rewind) begin
        cur_idx <= start_q;
      end else if (finish_buf) begin
        cur_idx <= nxt_idx;
        if (cur_last) busy <= 1'b0;
      end
    end
  end

  // R3: a served demand is dropped unless re-requested
  a_r3_demand_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_fire && !demand_set) |=> !demand_q);
  // R4: a frame starts only from a ready descriptor
  a_r4_start_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cur_ready));
  // R10: a frame starts only while enabled
  a_r10_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(enable));
  // R5: the end-of-frame completion returns to idle
  a_r5_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done && !collision && cur_last) |=> !busy);
  // R6: an intermediate completion moves on without re-polling
  a_r6_chain_on: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done && !collision && !cur_last) |=> busy && cur_idx == $past(nxt_idx));
  // R7: a collision returns to the frame head
  a_r7_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && collision) |=> busy && cur_idx == $past(start_q));
endmodule

// File: rtl/txr_ring_poller.sv
module txr_ring_poller
  import txr_pkg::*;
#(
  parameter int NUM_DESC    = 8,
  parameter int POLL_CYCLES = 128,
  localparam int IDX_W = $clog2(NUM_DESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_enable,
  input  logic             dsc_wr_en,
  input  logic [IDX_W-1:0] dsc_wr_idx,
  input  logic             dsc_wr_ready,
  input  logic             dsc_wr_wrap,
  input  logic             dsc_wr_last,
  input  logic             dsc_wr_crc,
  input  logic [LEN_W-1:0] dsc_wr_len,
  input  logic             demand_set,
  input  logic [IDX_W-1:0] dsc_rd_idx,
  output logic             dsc_rd_ready,
  output logic [ST_W-1:0]  dsc_rd_status,
  output logic             demand_pending,
  output logic             buf_valid,
  output logic [IDX_W-1:0] buf_idx,
  output logic [LEN_W-1:0] buf_len,
  output logic             buf_last,
  output logic             buf_crc_append,
  input  logic             eng_done,
  input  logic             eng_collision,
  input  logic [ST_W-1:0]  eng_status
);
  txr_desc_t        wr_desc;
  txr_desc_t        cur_desc;
  txr_desc_t        rd_desc;
  logic             tick;
  logic             poll_fire;
  logic             timer_run;
  logic             upd_en;
  logic             upd_status_en;
  logic             busy;
  logic [IDX_W-1:0] cur_idx;
  logic             demand_q;

  assign wr_desc = '{ready: dsc_wr_ready, wrap: dsc_wr_wrap, last: dsc_wr_last,
                     crc: dsc_wr_crc, len: dsc_wr_len, status: '0};

  txr_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(timer_run), .restart(poll_fire), .tick(tick));

  txr_ring_ctrl #(.NUM_DESC(NUM_DESC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(tx_enable), .demand_set(demand_set),
    .tick(tick), .cur_ready(cur_desc.ready), .cur_last(cur_desc.last),
    .cur_wrap(cur_desc.wrap), .done(eng_done), .collision(eng_collision),
    .busy(busy), .cur_idx(cur_idx), .demand_q(demand_q), .poll_fire(poll_fire),
    .timer_run(timer_run), .upd_en(upd_en), .upd_status_en(upd_status_en));

  txr_desc_file #(.NUM_DESC(NUM_DESC)) u_descs (
    .clk(clk), .rst_n(rst_n), .wr_en(dsc_wr_en), .wr_idx(dsc_wr_idx),
    .wr_desc(wr_desc), .upd_en(upd_en), .upd_idx(cur_idx),
    .upd_status_en(upd_status_en), .upd_status(eng_status),
    .cur_idx(cur_idx), .cur_desc(cur_desc), .rd_idx(dsc_rd_idx), .rd_desc(rd_desc));

  assign dsc_rd_ready   = rd_desc.ready;
  assign dsc_rd_status  = rd_desc.status;
  assign demand_pending = demand_q;
  assign buf_valid      = busy;
  assign buf_idx        = cur_idx;
  assign buf_len        = cur_desc.len;
  assign buf_last       = cur_desc.last;
  assign buf_crc_append = cur_desc.crc && cur_desc.last;

  // R9: checksum request is never signalled for a mid-frame buffer
  a_r9_crc_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    buf_crc_append |-> buf_last);
  // R5: the end-of-frame status is stored into the finished entry
  a_r5_status_write: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && eng_done && !eng_collision && buf_last && !dsc_wr_en)
      |=> !buf_valid && $past(eng_status) == u_descs.ents[$past(buf_idx)].status);
endmodule

// File: tb/tb_txr_ring_poller.sv
module tb_txr_ring_poller;
  localparam int N = 8;
  localparam int POLL = 128;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_enable = 0, dsc_wr_en = 0, dsc_wr_ready = 0, dsc_wr_wrap = 0;
  logic dsc_wr_last = 0, dsc_wr_crc = 0, demand_set = 0;
  logic eng_done = 0, eng_collision = 0;
  logic [IW-1:0] dsc_wr_idx = '0, dsc_rd_idx = '0;
  logic [10:0] dsc_wr_len = '0;
  logic [3:0] eng_status = '0;
  logic dsc_rd_ready, demand_pending, buf_valid, buf_last, buf_crc_append;
  logic [3:0] dsc_rd_status;
  logic [IW-1:0] buf_idx;
  logic [10:0] buf_len;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural reference state
  int  m_timer = 0, m_cur = 0, m_start = 0;
  bit  m_busy = 0, m_dem = 0;
  bit  m_rdy[N], m_wrap[N], m_last[N], m_crc[N];
  int  m_len[N], m_st[N];

  always #4 clk = ~clk;

  txr_ring_poller #(.NUM_DESC(N), .POLL_CYCLES(POLL)) dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_timer = 0; m_cur = 0; m_start = 0; m_busy = 0; m_dem = 0;
      for (int i = 0; i < N; i++) begin
        m_rdy[i] = 0; m_wrap[i] = 0; m_last[i] = 0; m_crc[i] = 0; m_len[i] = 0; m_st[i] = 0;
      end
    end else begin
      bit go;
      int c;
      go = tx_enable && !m_busy && (m_timer == POLL - 1 || m_dem);
      m_timer = (!tx_enable || m_busy || go) ? 0 : m_timer + 1;
      m_dem = demand_set || (m_dem && !go);
      c = m_cur;
      if (go && m_rdy[c]) begin
        m_busy = 1; m_start = c;
      end else if (m_busy && eng_collision) begin
        m_cur = m_start;
      end else if (m_busy && eng_done) begin
        m_rdy[c] = 0;
        if (m_last[c]) begin m_st[c] = eng_status; m_busy = 0; end
        m_cur = (m_wrap[c] || c == N - 1) ? 0 : c + 1;
      end
      if (dsc_wr_en) begin
        m_rdy[dsc_wr_idx] = dsc_wr_ready; m_wrap[dsc_wr_idx] = dsc_wr_wrap;
        m_last[dsc_wr_idx] = dsc_wr_last; m_crc[dsc_wr_idx] = dsc_wr_crc;
        m_len[dsc_wr_idx] = dsc_wr_len; m_st[dsc_wr_idx] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 buf_valid", buf_valid, m_busy);
      check("R7 buf_idx", buf_idx, m_cur);
      check("R6 buf_len", buf_len, m_len[m_cur]);
      check("R5 buf_last", buf_last, m_last[m_cur]);
      check("R9 buf_crc_append", buf_crc_append, m_crc[m_cur] && m_last[m_cur]);
      check("R3 demand_pending", demand_pending, m_dem);
      check("R6 rd_ready", dsc_rd_ready, m_rdy[dsc_rd_idx]);
      check("R5 rd_status", dsc_rd_status, m_st[dsc_rd_idx]);
    end
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int idx, input bit rdy, input bit wrp, input bit lst,
                    input bit crc, input int len);
    dsc_wr_en = 1; dsc_wr_idx = IW'(idx); dsc_wr_ready = rdy; dsc_wr_wrap = wrp;
    dsc_wr_last = lst; dsc_wr_crc = crc; dsc_wr_len = 11'(len);
    cyc();
    dsc_wr_en = 0;
  endtask

  task automatic demand();
    demand_set = 1; cyc(); demand_set = 0;
  endtask

  task automatic done(input int st);
    eng_done = 1; eng_status = 4'(st); cyc(); eng_done = 0;
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    for (int i = 0; i < N; i++) begin
      dsc_rd_idx = IW'(i); #1;
      check("R1 ready after reset", dsc_rd_ready, 0);
      check("R1 status after reset", dsc_rd_status, 0);
    end
    check("R1 buf_valid", buf_valid, 0);
    check("R1 buf_idx", buf_idx, 0);
    check("R1 demand_pending", demand_pending, 0);

    // R2 periodic poll, R9 checksum on a single-buffer frame
    wr(0, 1, 0, 1, 1, 64);
    tx_enable = 1;
    cyc();
    repeat (126) cyc();
    check("R2 no poll before interval", buf_valid, 0);
    cyc();
    check("R2 poll at interval", buf_valid, 1);
    check("R2 index", buf_idx, 0);
    check("R9 crc on last", buf_crc_append, 1);
    dsc_rd_idx = 0;
    done(5);
    check("R5 status written", dsc_rd_status, 5);
    check("R5 ready cleared", dsc_rd_ready, 0);
    check("R5 idle after last", buf_valid, 0);

    // R3 on-demand poll
    wr(1, 1, 0, 1, 0, 80);
    demand();
    check("R3 pending", demand_pending, 1);
    check("R3 not yet started", buf_valid, 0);
    cyc();
    check("R3 started", buf_valid, 1);
    check("R3 pending cleared", demand_pending, 0);
    check("R9 no crc when not requested", buf_crc_append, 0);
    done(2);

    // R4 poll of a descriptor that is not ready
    demand(); cyc(); cyc();
    check("R4 nothing handed", buf_valid, 0);
    check("R4 position kept", buf_idx, 2);

    // R6 / R7 multi-buffer frame written tail first
    wr(4, 1, 0, 1, 1, 30);
    wr(3, 1, 0, 0, 1, 20);
    wr(2, 1, 0, 0, 0, 10);
    demand(); cyc();
    check("R6 frame head", buf_idx, 2);
    dsc_rd_idx = 2;
    done(7);
    check("R6 chained to next", buf_idx, 3);
    check("R6 still valid", buf_valid, 1);
    check("R6 ready cleared", dsc_rd_ready, 0);
    check("R6 status untouched", dsc_rd_status, 0);
    check("R9 no crc mid-frame", buf_crc_append, 0);
    eng_collision = 1; cyc(); eng_collision = 0;
    check("R7 rewind to head", buf_idx, 2);
    check("R7 held valid", buf_valid, 1);
    done(0); done(0);
    check("R9 crc on frame end", buf_crc_append, 1);
    dsc_rd_idx = 4;
    done(9);
    check("R5 status on frame end", dsc_rd_status, 9);
    check("R5 idle after frame", buf_valid, 0);

    // R8 wrap flag
    wr(5, 1, 1, 1, 0, 40);
    demand(); cyc();
    check("R8 at entry 5", buf_idx, 5);
    done(1);
    check("R8 wrapped to 0", buf_idx, 0);
    wr(0, 1, 0, 1, 0, 50);
    demand(); cyc();
    check("R8 entry 0 served", buf_valid, 1);
    done(3);

    // R10 disabled poller
    tx_enable = 0;
    wr(1, 1, 0, 1, 0, 60);
    demand();
    repeat (5) cyc();
    check("R10 no poll while disabled", buf_valid, 0);
    check("R10 demand kept", demand_pending, 1);
    tx_enable = 1;
    cyc();
    check("R10 served after enable", buf_valid, 1);
    check("R10 index", buf_idx, 1);
    done(4);
    repeat (3) cyc();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule